// File: doc/BRIEF.md
# Timer Host Register Interface

This block is the byte-wide host register file that sits in front of a group of counter channels. The host sees four byte addresses. The highest address takes control words; each lower address is the data port of one channel. The block turns control words into per-channel programming and latch actions, and it joins byte writes into 16-bit count loads. It holds latched counts and latched status bytes until the host reads them, and it returns the right byte on every read.

Each channel receives a one-cycle load strobe with the assembled count, its current counting mode and BCD flag, and a one-cycle pulse whenever a fresh count latch is taken. The counting logic lives outside the block. It supplies each channel's live count and output level, and the block samples them on reads and latches.

Top module: `tmr_host_regs`

## Requirements
- R1: A control write to address 3 whose top bits `wdata[7:6]` name a channel (0..2) and whose access field `wdata[5:4]` is nonzero sets that channel's mode output from `wdata[3:1]` and its BCD output from `wdata[0]`, one cycle later. Codes 6 and 7 appear as 2 and 3.
- R2: With access field 1 (low byte only), a data write of byte b pulses the load strobe for one cycle with count `{8'h00, b}`.
- R3: With access field 2 (high byte only), a data write of byte b loads count `{b, 8'h00}`.
- R4: With access field 3 (word), the first data write is held and produces no strobe. The second write loads `{second, first}`, and the pattern then repeats.
- R5: A control word with access field 0 is a count-latch command for the selected channel. It leaves mode, BCD and access unchanged and captures the live count. Reads then return the captured bytes in the channel's access order (word: low then high) and afterwards go back to live reads.
- R6: While a latched count, or a latched status, is still unread, a further latch request of the same kind for that channel is ignored.
- R7: A control word with `wdata[7:6]=3` is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. `wdata[5]=0` latches the count and `wdata[4]=0` latches the status, both for every selected channel at once.
- R8: The latched status byte is `{out, 1'b0, access[1:0], mode[2:0], bcd}`, where `out` is the channel output level at the time of the latch.
- R9: A read returns the latched status first if there is one, then the latched count, and only after both the live count.
- R10: In word access, live reads alternate low byte and high byte, starting with the low byte. This alternation is independent of the write byte sequence. `rdata` is registered and changes only in the cycle after a read.
- R11: Programming a channel resets both its write byte position and its live-read byte position to the first byte.
- R12: After reset, `rdata` is 0, no strobe or latch pulse is active, every mode output is 0, every BCD output is 0, and every channel is in word access.
- R13: `lat_req` for a channel pulses for one cycle after each count latch that is accepted, and does not pulse for an ignored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Host byte address (3 = control) |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Registered host read byte |
| live_cnt | input | 48 | Live count of each channel, 16 bits per channel |
| live_out | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle count load strobe per channel |
| ld_val | output | 48 | Assembled count per channel |
| lat_req | output | 3 | One-cycle accepted count-latch pulse per channel |
| ch_mode | output | 9 | Counting mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
Directed sequences cover each access mode on its own channel. Word-mode writes are interleaved with live reads, which separates the write byte position from the read byte position. Repeated latches with a changing live count separate a held capture from a fresh one, and read-back commands that ask for both status and count separate the read priority. Random control words, data writes, reads and read-backs then run with a changing live count and output level. These expose any mix-up between channels, or any byte-position state that leaks between a reprogramming and the data traffic around it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MW = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    LAT_NONE   = 2'd0,
    LAT_LO_END = 2'd1,
    LAT_HI_END = 2'd2,
    LAT_LO_HI  = 2'd3
  } lat_e;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] cnt_lat,
  output logic [NCH-1:0] st_lat,
  output logic [NCH-1:0] dat_wr
);
  localparam logic [AW-1:0] CTRL_ADDR = {AW{1'b1}};
  localparam logic [1:0]    SEL_RB    = 2'b11;

  logic       is_ctrl;
  logic [1:0] sel;
  logic [1:0] acc;

  assign is_ctrl = wr_en && (addr == CTRL_ADDR);
  assign sel     = wdata[7:6];
  assign acc     = wdata[5:4];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit, rb_hit;
    assign hit        = is_ctrl && (sel == 2'(g));
    assign rb_hit     = is_ctrl && (sel == SEL_RB) && wdata[g+1];
    assign prog[g]    = hit && (acc != 2'b00);
    assign cnt_lat[g] = (hit && (acc == 2'b00)) || (rb_hit && !wdata[5]);
    assign st_lat[g]  = rb_hit && !wdata[4];
    assign dat_wr[g]  = wr_en && (addr == AW'(g));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog,
  input  logic               cnt_lat,
  input  logic               st_lat,
  input  logic               dat_wr,
  input  logic               rd_sel,
  input  logic [CW/2-1:0]    wbyte,
  input  logic [CW-1:0]      live_cnt,
  input  logic               live_out,
  output logic               ld_stb,
  output logic [CW-1:0]      ld_val,
  output logic               lat_req,
  output logic [MW-1:0]      mode_o,
  output logic               bcd_o,
  output logic [CW/2-1:0]    rd_byte
);
  localparam int BW = CW / 2;

  acc_e          acc;
  lat_e          lst;
  logic          wph, rph, sv;
  logic [BW-1:0] hold, sbyte;
  logic [CW-1:0] lcnt;
  logic [MW-1:0] mreq, mfix;

  assign mreq = wbyte[3:1];
  assign mfix = (mreq[2:1] == 2'b11) ? {1'b0, mreq[1:0]} : mreq;

  // byte a read would return now
  always_comb begin
    rd_byte = live_cnt[BW-1:0];
    if (sv) begin
      rd_byte = sbyte;
    end else if (lst != LAT_NONE) begin
      rd_byte = (lst == LAT_HI_END) ? lcnt[CW-1:BW] : lcnt[BW-1:0];
    end else begin
      case (acc)
        ACC_HI:   rd_byte = live_cnt[CW-1:BW];
        ACC_WORD: rd_byte = rph ? live_cnt[CW-1:BW] : live_cnt[BW-1:0];
        default:  rd_byte = live_cnt[BW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= ACC_WORD;
      mode_o  <= '0;
      bcd_o   <= 1'b0;
      wph     <= 1'b0;
      rph     <= 1'b0;
      hold    <= '0;
      lst     <= LAT_NONE;
      lcnt    <= '0;
      sv      <= 1'b0;
      sbyte   <= '0;
      ld_stb  <= 1'b0;
      ld_val  <= '0;
      lat_req <= 1'b0;
    end else begin
      ld_stb  <= 1'b0;
      lat_req <= 1'b0;
      if (rd_sel) begin
        if (sv)                    sv  <= 1'b0;
        else if (lst == LAT_LO_HI) lst <= LAT_HI_END;
        else if (lst != LAT_NONE)  lst <= LAT_NONE;
        else if (acc == ACC_WORD)  rph <= ~rph;
      end
      if (dat_wr) begin
        case (acc)
          ACC_LO: begin
            ld_stb <= 1'b1;
            ld_val <= {{BW{1'b0}}, wbyte};
          end
          ACC_HI: begin
            ld_stb <= 1'b1;
            ld_val <= {wbyte, {BW{1'b0}}};
          end
          ACC_WORD: begin
            if (!wph) begin
              hold <= wbyte;
              wph  <= 1'b1;
            end else begin
              ld_stb <= 1'b1;
              ld_val <= {wbyte, hold};
              wph    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (prog) begin
        acc    <= acc_e'(wbyte[5:4]);
        mode_o <= mfix;
        bcd_o  <= wbyte[0];
        wph    <= 1'b0;
        rph    <= 1'b0;
      end
      if (cnt_lat && (lst == LAT_NONE)) begin
        lcnt    <= live_cnt;
        lat_req <= 1'b1;
        case (acc)
          ACC_LO:  lst <= LAT_LO_END;
          ACC_HI:  lst <= LAT_HI_END;
          default: lst <= LAT_LO_HI;
        endcase
      end
      if (st_lat && !sv) begin
        sv    <= 1'b1;
        sbyte <= {live_out, 1'b0, acc, mode_o, bcd_o};
      end
    end
  end
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [CW/2-1:0]   wdata,
  output logic [CW/2-1:0]   rdata,
  input  logic [NCH*CW-1:0] live_cnt,
  input  logic [NCH-1:0]    live_out,
  output logic [NCH-1:0]    ld_stb,
  output logic [NCH*CW-1:0] ld_val,
  output logic [NCH-1:0]    lat_req,
  output logic [NCH*MW-1:0] ch_mode,
  output logic [NCH-1:0]    ch_bcd
);
  localparam int BW = CW / 2;

  logic [NCH-1:0] prog, cnt_lat, st_lat, dat_wr;
  logic [BW-1:0]  rd_bytes [NCH];
  logic [BW-1:0]  rd_nxt;

  tmr_ctl_decode #(.NCH(NCH), .AW(AW), .BW(BW)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .prog    (prog),
    .cnt_lat (cnt_lat),
    .st_lat  (st_lat),
    .dat_wr  (dat_wr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_regs #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .prog     (prog[g]),
      .cnt_lat  (cnt_lat[g]),
      .st_lat   (st_lat[g]),
      .dat_wr   (dat_wr[g]),
      .rd_sel   (rd_en && (addr == AW'(g))),
      .wbyte    (wdata),
      .live_cnt (live_cnt[g*CW +: CW]),
      .live_out (live_out[g]),
      .ld_stb   (ld_stb[g]),
      .ld_val   (ld_val[g*CW +: CW]),
      .lat_req  (lat_req[g]),
      .mode_o   (ch_mode[g*MW +: MW]),
      .bcd_o    (ch_bcd[g]),
      .rd_byte  (rd_bytes[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rd_nxt = rd_bytes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int AW  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [CW/2-1:0]   wdata,
  input logic [CW/2-1:0]   rdata,
  input logic [NCH-1:0]    ld_stb,
  input logic [NCH*CW-1:0] ld_val,
  input logic [NCH-1:0]    lat_req,
  input logic [NCH*3-1:0]  ch_mode
);
  localparam int BW = CW / 2;
  localparam logic [AW-1:0] CTRL_ADDR = {AW{1'b1}};

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata)); // R10

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      ld_stb[g] |-> $past(wr_en && (addr == AW'(g)))); // R2

    AST_LOAD_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
      ld_stb[g] |-> ((ld_val[g*CW +: BW] == $past(wdata)) ||
                     (ld_val[g*CW+BW +: BW] == $past(wdata)))); // R4

    AST_LATCH_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
      lat_req[g] |-> $past(wr_en && (addr == CTRL_ADDR))); // R13

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      ch_mode[g*3 +: 3] <= 3'd5); // R1

    AST_MODE_ONLY_BY_CTRL: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en && (addr == CTRL_ADDR)) |-> $stable(ch_mode[g*3 +: 3])); // R5
  end
endmodule

bind tmr_host_regs tmr_host_regs_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .ld_stb  (ld_stb),
  .ld_val  (ld_val),
  .lat_req (lat_req),
  .ch_mode (ch_mode)
);

// File: tb/sim_tmr_host_regs.sv
module sim_tmr_host_regs;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int AW  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst, wr_en, rd_en;
  logic [AW-1:0]     addr;
  logic [7:0]        wdata, rdata;
  logic [NCH*CW-1:0] live_cnt, ld_val;
  logic [NCH-1:0]    live_out, ld_stb, lat_req, ch_bcd;
  logic [NCH*3-1:0]  ch_mode;

  logic [15:0] live [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_live
    assign live_cnt[g*CW +: CW] = live[g];
  end

  tmr_host_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .live_out(live_out),
    .ld_stb(ld_stb), .ld_val(ld_val), .lat_req(lat_req),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  // reference model state
  int          m_acc [NCH], m_mode [NCH], m_bcd [NCH];
  int          m_wph [NCH], m_rph [NCH], m_lst [NCH], m_sv [NCH];
  logic [7:0]  m_hold [NCH], m_sb [NCH];
  logic [15:0] m_lc [NCH];
  logic [NCH-1:0] e_stb, e_lreq;
  logic [15:0] e_val [NCH];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wph[c] = 0; m_rph[c] = 0;
      m_lst[c] = 0; m_sv[c] = 0; m_hold[c] = 0; m_sb[c] = 0; m_lc[c] = 0;
      e_val[c] = 0;
    end
  endtask

  task automatic mdl_lat_cnt(int c);
    if (m_lst[c] == 0) begin
      m_lc[c] = live[c];
      m_lst[c] = (m_acc[c] == 1) ? 1 : (m_acc[c] == 2) ? 2 : 3;
      e_lreq[c] = 1'b1;
    end
  endtask

  task automatic mdl_lat_st(int c);
    if (m_sv[c] == 0) begin
      m_sb[c] = {live_out[c], 1'b0, 2'(m_acc[c]), 3'(m_mode[c]), 1'(m_bcd[c])};
      m_sv[c] = 1;
    end
  endtask

  task automatic mdl_write(int a, logic [7:0] d);
    e_stb = '0; e_lreq = '0;
    if (a == 3) begin
      if (d[7:6] == 2'b11) begin
        for (int c = 0; c < NCH; c++) if (d[c+1]) begin
          if (!d[5]) mdl_lat_cnt(c);
          if (!d[4]) mdl_lat_st(c);
        end
      end else if (d[5:4] == 2'b00) begin
        mdl_lat_cnt(int'(d[7:6]));
      end else begin
        int c = int'(d[7:6]);
        m_acc[c] = int'(d[5:4]);
        m_mode[c] = (d[3:1] > 3'd5) ? int'(d[3:1]) - 4 : int'(d[3:1]);
        m_bcd[c] = int'(d[0]);
        m_wph[c] = 0; m_rph[c] = 0;
      end
    end else begin
      case (m_acc[a])
        1: begin e_stb[a] = 1'b1; e_val[a] = {8'h00, d}; end
        2: begin e_stb[a] = 1'b1; e_val[a] = {d, 8'h00}; end
        default: begin
          if (m_wph[a] == 0) begin m_hold[a] = d; m_wph[a] = 1; end
          else begin e_stb[a] = 1'b1; e_val[a] = {d, m_hold[a]}; m_wph[a] = 0; end
        end
      endcase
    end
  endtask

  task automatic mdl_read(int a, output logic [7:0] r);
    r = 8'h00;
    if (a == 3) r = 8'h00;
    else if (m_sv[a] != 0) begin r = m_sb[a]; m_sv[a] = 0; end
    else if (m_lst[a] != 0) begin
      case (m_lst[a])
        1: begin r = m_lc[a][7:0];  m_lst[a] = 0; end
        2: begin r = m_lc[a][15:8]; m_lst[a] = 0; end
        default: begin r = m_lc[a][7:0]; m_lst[a] = 2; end
      endcase
    end else begin
      case (m_acc[a])
        1: r = live[a][7:0];
        2: r = live[a][15:8];
        default: begin
          r = (m_rph[a] != 0) ? live[a][15:8] : live[a][7:0];
          m_rph[a] ^= 1;
        end
      endcase
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(int a, logic [7:0] d, string tag);
    mdl_write(a, d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " stb"}, ld_stb[c], e_stb[c]);
      if (e_stb[c]) chk({tag, " val"}, ld_val[c*CW +: CW], e_val[c]);
      chk({tag, " R13 lat_req"}, lat_req[c], e_lreq[c]);
      chk({tag, " mode"}, ch_mode[c*3 +: 3], m_mode[c]);
      chk({tag, " bcd"}, ch_bcd[c], m_bcd[c]);
    end
  endtask

  task automatic rd(int a, string tag);
    logic [7:0] e;
    mdl_read(a, e);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rdata"}, rdata, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    live_out = '0;
    for (int c = 0; c < NCH; c++) live[c] = 16'h0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 rdata", rdata, 0);
    chk("R12 stb", ld_stb, 0);
    chk("R12 lat_req", lat_req, 0);
    chk("R12 mode", ch_mode, 0);
    chk("R12 bcd", ch_bcd, 0);
    live[0] = 16'hA1B2;
    rd(0, "R12 word lo");
    rd(0, "R12 word hi");

    // R1 mode remap
    wr(3, 8'b00_11_110_1, "R1");
    wr(3, 8'b01_11_111_0, "R1");
    wr(3, 8'b10_11_101_1, "R1");

    // R2 low-only
    wr(3, 8'b00_01_000_0, "R2");
    wr(0, 8'hA5, "R2");
    // R3 high-only
    wr(3, 8'b01_10_011_0, "R3");
    wr(1, 8'h3C, "R3");
    // R4 word
    wr(3, 8'b10_11_000_0, "R4");
    wr(2, 8'h11, "R4");
    wr(2, 8'h22, "R4");
    wr(2, 8'h77, "R4");

    // R10 live reads independent of writes (ch2 write phase is 1 here)
    live[2] = 16'hBEEF;
    rd(2, "R10");
    wr(2, 8'h88, "R10");
    rd(2, "R10");
    rd(2, "R10");

    // R11 reprogram resets both phases
    wr(2, 8'h44, "R11");
    rd(2, "R11");
    wr(3, 8'b10_11_010_0, "R11");
    wr(2, 8'h55, "R11");
    wr(2, 8'h66, "R11");
    rd(2, "R11");

    // R5 count latch, programming kept
    live[2] = 16'h1234;
    wr(3, 8'b10_00_000_0, "R5");
    live[2] = 16'h9999;
    rd(2, "R5");
    rd(2, "R5");
    rd(2, "R5");

    // R6 second latch ignored
    live[2] = 16'h1111;
    wr(3, 8'b10_00_000_0, "R6");
    live[2] = 16'h2222;
    wr(3, 8'b10_00_000_0, "R6");
    rd(2, "R6");
    rd(2, "R6");

    // R7 R8 R9 read-back of count and status on all channels
    live[0] = 16'h0F0E; live[1] = 16'hC0DE; live[2] = 16'h5A6B;
    live_out = 3'b101;
    wr(3, 8'b11_00_1110, "R7");
    wr(3, 8'b11_00_1110, "R6 rb");
    live_out = 3'b010;
    for (int c = 0; c < NCH; c++) begin
      rd(c, "R8 R9 status");
      rd(c, "R9 count");
    end
    rd(2, "R9 count hi");
    rd(2, "R9 live");
    // count-only read-back on channels 0 and 1
    live[0] = 16'h4455; live[1] = 16'h6677;
    wr(3, 8'b11_01_0110, "R7");
    rd(0, "R7");
    rd(1, "R7");
    rd(3, "R10 ctrl read");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      live[$urandom_range(0, NCH-1)] = 16'($urandom);
      live_out = 3'($urandom);
      case (op)
        0, 1: begin
          logic [7:0] d;
          d = 8'($urandom);
          if (d[7:6] != 2'b11 && d[5:4] == 2'b00 && $urandom_range(0, 1) == 1) d[4] = 1'b1;
          wr(3, d, "R1 rnd ctrl");
        end
        2, 3, 4: wr($urandom_range(0, NCH-1), 8'($urandom), "R4 rnd data");
        default: rd($urandom_range(0, NCH-1), "R9 rnd read");
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule